// File: doc/BRIEF.md
# Predicated Quadword Gather Load Sequencer

This block assembles a destination vector image of 128-bit lanes by gathering each lane from memory. It is given a vector of per-lane base addresses, a 64-bit scalar offset with a register selector, and a predicate holding one bit per byte of the vector. On a start pulse it walks the lanes from lane 0 upward. For each active lane it issues one 128-bit read over a single-outstanding valid/ready memory port and writes the returned data into that lane. Inactive lanes stay zero and never reach memory.

When the last lane has been handled, the block pulses done for one cycle. The assembled vector stays on its result output until the next accepted start. If no lane is active, the block skips memory entirely and reports done on the cycle after start. The vector length is a parameter and must be a multiple of 128 bits.

Top module: `gather_seq`

## Requirements
- R1: Lane e is active exactly when predicate bit 16*e is set. The other fifteen bits of each lane's 16-bit predicate group have no effect on requests or result.
- R2: The request address for lane e is the low 64 bits of the base lane, bits [128*e+63 : 128*e] of base_vec_i, plus the 64-bit offset, taken modulo 2^64. The upper 64 bits of each base lane are ignored.
- R3: When off_sel_i equals 31, the offset is zero whatever off_val_i holds. Any other selector value uses off_val_i.
- R4: An inactive lane issues no request, and its result bits [128*e+127 : 128*e] are all zero.
- R5: Requests are issued in ascending lane order. The response data for lane e lands in result bits [128*e+127 : 128*e].
- R6: With no active lane, no request is issued, done_o rises in the cycle after start is accepted, and result_o is all zero.
- R7: While req_valid_o is high and req_ready_i is low, req_valid_o stays high and req_addr_o stays stable. After a request handshake, no new request is raised until its response arrives, so at most one request is outstanding.
- R8: start_i is ignored while busy_o is high. The running gather and its result are unaffected.
- R9: done_o is a one-cycle pulse, and result_o holds the complete vector at that cycle. In the following cycle busy_o is low.
- R10: After reset, busy_o, done_o and req_valid_o are low and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| base_vec_i | input | VL_BITS | Base address vector, 128 bits per lane |
| off_val_i | input | 64 | Scalar offset value |
| off_sel_i | input | 5 | Offset register selector; 31 means zero offset |
| pred_i | input | VL_BITS/8 | Governing predicate, one bit per byte |
| req_valid_o | output | 1 | Memory read request valid |
| req_ready_i | input | 1 | Memory read request ready |
| req_addr_o | output | 64 | Memory read address |
| rsp_valid_i | input | 1 | Memory response valid |
| rsp_data_i | input | 128 | Memory response data |
| busy_o | output | 1 | Gather in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | VL_BITS | Assembled result vector |

## Verification
The hardest case to reach from the ports is a start pulse that arrives while a request is stalled under backpressure, or while a response is still pending. In that case the second pulse must leave both the address sequence and the captured inputs untouched. The bench drives random ready and response delays from a seeded generator, so stalls of several cycles are common. Partway through selected runs it also raises start again with different bases, offsets and predicate. It then compares every logged request address and the final vector against values computed from the first inputs. Exhaustive sweeps over all sixteen activity patterns of a four-lane configuration cover the empty and full cases. Predicate noise bits, the zero-offset selector and an address sum that wraps past 2^64 are mixed into the sweeps.

// File: rtl/gq_pkg.sv
package gq_pkg;
  localparam int unsigned LANE_W   = 128;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned PBITS_LN = LANE_W / 8;
  localparam logic [4:0]  SEL_ZERO = 5'd31;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } gq_state_e;
endpackage

// File: rtl/gq_act_extract.sv
module gq_act_extract
  import gq_pkg::*;
#(
  parameter int unsigned N_LANES = 4
) (
  input  logic [N_LANES*PBITS_LN-1:0] pred_i,
  output logic [N_LANES-1:0]          act_o
);
  for (genvar e = 0; e < N_LANES; e++) begin : g_lane
    assign act_o[e] = pred_i[e*PBITS_LN];
  end
endmodule

// File: rtl/gq_addr_gen.sv
module gq_addr_gen
  import gq_pkg::*;
#(
  parameter int unsigned N_LANES = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [N_LANES*LANE_W-1:0] base_vec_i,
  input  logic [ADDR_W-1:0]         off_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [ADDR_W-1:0]         addr_o
);
  logic [ADDR_W-1:0] lo_half [N_LANES];

  for (genvar e = 0; e < N_LANES; e++) begin : g_lo
    assign lo_half[e] = base_vec_i[e*LANE_W +: ADDR_W];
  end

  // modulo 2^64 add, carry dropped
  assign addr_o = lo_half[idx_i] + off_i;
endmodule

// File: rtl/gather_seq.sv
module gather_seq
  import gq_pkg::*;
#(
  parameter int unsigned VL_BITS = 512
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [VL_BITS-1:0]   base_vec_i,
  input  logic [ADDR_W-1:0]    off_val_i,
  input  logic [4:0]           off_sel_i,
  input  logic [VL_BITS/8-1:0] pred_i,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [ADDR_W-1:0]    req_addr_o,
  input  logic                 rsp_valid_i,
  input  logic [LANE_W-1:0]    rsp_data_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [VL_BITS-1:0]   result_o
);
  localparam int unsigned N_LANES = VL_BITS / LANE_W;
  localparam int unsigned IDX_W   = (N_LANES > 1) ? $clog2(N_LANES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_LANES - 1);

  gq_state_e            state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [N_LANES-1:0]   mask_q;
  logic [VL_BITS-1:0]   base_q;
  logic [ADDR_W-1:0]    off_q;
  logic [VL_BITS-1:0]   res_q;
  logic [N_LANES-1:0]   act_in;
  logic                 any_act;
  logic                 last_lane;
  logic                 cur_act;

  gq_act_extract #(.N_LANES(N_LANES)) u_act (
    .pred_i (pred_i),
    .act_o  (act_in)
  );

  gq_addr_gen #(.N_LANES(N_LANES), .IDX_W(IDX_W)) u_addr (
    .base_vec_i (base_q),
    .off_i      (off_q),
    .idx_i      (idx_q),
    .addr_o     (req_addr_o)
  );

  assign any_act   = |act_in;
  assign last_lane = (idx_q == LAST_IDX);
  assign cur_act   = mask_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mask_q  <= '0;
      base_q  <= '0;
      off_q   <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            res_q <= '0;
            idx_q <= '0;
            if (any_act) begin
              // operands captured only when some lane is live
              mask_q  <= act_in;
              base_q  <= base_vec_i;
              off_q   <= (off_sel_i == SEL_ZERO) ? '0 : off_val_i;
              state_q <= ST_ISSUE;
            end else begin
              state_q <= ST_FIN;
            end
          end
        end
        ST_ISSUE: begin
          if (!cur_act) begin
            if (last_lane) state_q <= ST_FIN;
            else           idx_q   <= idx_q + 1'b1;
          end else if (req_ready_i) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid_i) begin
            res_q[idx_q*LANE_W +: LANE_W] <= rsp_data_i;
            if (last_lane) begin
              state_q <= ST_FIN;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_ISSUE) && cur_act;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign result_o    = res_q;
endmodule

// File: rtl/gather_seq_chk.sv
module gather_seq_chk
  import gq_pkg::*;
#(
  parameter int unsigned VL_BITS = 512
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [VL_BITS/8-1:0] pred_i,
  input logic                 req_valid_o,
  input logic                 req_ready_i,
  input logic [ADDR_W-1:0]    req_addr_o,
  input logic                 busy_o,
  input logic                 done_o
);
  localparam int unsigned N_LANES = VL_BITS / LANE_W;

  logic any_live;
  always_comb begin
    any_live = 1'b0;
    for (int e = 0; e < N_LANES; e++) any_live = any_live | pred_i[e*PBITS_LN];
  end

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

  p_one_outstanding_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=> !req_valid_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  p_empty_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !any_live |=> done_o);

  p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o && !done_o |=> busy_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o && !done_o);
endmodule

bind gather_seq gather_seq_chk #(.VL_BITS(VL_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .pred_i      (pred_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/sim_gather_seq.sv
module sim_gather_seq;
  localparam int unsigned VL     = 512;
  localparam int unsigned NL     = VL / 128;
  localparam time         T_CLK  = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [VL-1:0]   base_vec = '0;
  logic [63:0]     off_val = '0;
  logic [4:0]      off_sel = '0;
  logic [VL/8-1:0] pred = '0;
  logic            req_valid;
  logic            req_ready = 1'b0;
  logic [63:0]     req_addr;
  logic            rsp_valid = 1'b0;
  logic [127:0]    rsp_data = '0;
  logic            busy, done;
  logic [VL-1:0]   result;

  int errors = 0;
  int checks = 0;

  logic [63:0] addr_log [16];
  int          n_req = 0;
  logic        pend = 1'b0;
  logic [63:0] pend_addr = '0;

  always #(T_CLK/2) clk = ~clk;

  gather_seq #(.VL_BITS(VL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_vec_i(base_vec),
    .off_val_i(off_val), .off_sel_i(off_sel), .pred_i(pred),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic logic [127:0] mem_word(logic [63:0] a);
    return {~a, a + 64'h0000_1234_5678_9abc};
  endfunction

  task automatic chk(string req, logic [VL-1:0] act, logic [VL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random ready and response delay
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend && ($urandom_range(0, 2) == 0)) begin
        rsp_valid = 1'b1;
        rsp_data  = mem_word(pend_addr);
        pend      = 1'b0;
      end
      req_ready = ($urandom_range(0, 2) != 0);
      if (req_valid && req_ready) begin
        if (n_req < 16) addr_log[n_req] = req_addr;
        n_req++;
        pend      = 1'b1;
        pend_addr = req_addr;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic run_case(logic [VL/8-1:0] p, logic [VL-1:0] b, logic [63:0] ov,
                          logic [4:0] sel, bit restart);
    logic [VL-1:0] exp_res;
    logic [63:0]   exp_addr [16];
    logic [63:0]   off_eff;
    int            n_exp;
    int            wait_n;
    off_eff = (sel == 5'd31) ? 64'd0 : ov;
    exp_res = '0;
    n_exp   = 0;
    for (int e = 0; e < NL; e++) begin
      if (p[16*e]) begin
        exp_addr[n_exp] = b[128*e +: 64] + off_eff;
        exp_res[128*e +: 128] = mem_word(exp_addr[n_exp]);
        n_exp++;
      end
    end
    n_req = 0;
    pred = p; base_vec = b; off_val = ov; off_sel = sel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n_exp == 0) begin
      chk("R6 done after start", VL'(done), VL'(1));
      chk("R6 zero result", result, '0);
    end else begin
      wait_n = 0;
      while (!done && wait_n < 4000) begin
        if (restart && wait_n == 3) begin
          // R8: second start while busy, other operands
          pred = ~p; base_vec = ~b; off_val = ~ov; off_sel = 5'd0;
          start = 1'b1;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
        wait_n++;
      end
      start = 1'b0;
      chk("R9 done reached", VL'(done), VL'(1));
      chk(restart ? "R8 result unchanged by busy start" : "R4 R5 result lanes",
          result, exp_res);
    end
    chk("R4 request count", VL'(n_req), VL'(n_exp));
    for (int k = 0; k < n_exp && k < n_req; k++)
      chk(sel == 5'd31 ? "R3 zero-offset address" : "R2 R5 address order",
          VL'(addr_log[k]), VL'(exp_addr[k]));
    @(negedge clk);
    chk("R9 done one cycle", VL'(done), VL'(0));
    chk("R9 idle after done", VL'(busy), VL'(0));
    chk("R9 result held", result, exp_res);
  endtask

  initial begin
    logic [VL/8-1:0] p;
    logic [VL-1:0]   b;
    logic [63:0]     ov;
    repeat (3) @(negedge clk);
    chk("R10 reset busy", VL'(busy), VL'(0));
    chk("R10 reset done", VL'(done), VL'(0));
    chk("R10 reset req", VL'(req_valid), VL'(0));
    chk("R10 reset result", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 4; k++) begin
        p = '0;
        // R1: odd variants add noise on non-governing predicate bits
        if (k[0]) for (int i = 0; i < VL/8; i++) p[i] = ($urandom_range(0, 1) == 1);
        for (int e = 0; e < NL; e++) p[16*e] = m[e];
        for (int w = 0; w < VL/32; w++) b[32*w +: 32] = $urandom;
        ov = {$urandom, $urandom};
        if (k == 2) begin
          // R2: sum wraps past 2^64
          ov = 64'hFFFF_FFFF_FFFF_FF00;
          for (int e = 0; e < NL; e++) b[128*e +: 64] = 64'h0000_0000_0000_0200 + 64'(e);
        end
        run_case(p, b, ov, (k == 3) ? 5'd31 : 5'(m), (k == 1) && (m != 0));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule